// File: doc/BRIEF.md
# Trace Buffer Recording Controller

This block captures trace packets from a processor core into a 64-entry circular store. Packets arrive on a narrow input with a valid strobe. A packer joins a fixed number of them into one stored entry. A small state machine gates recording. Once enabled it waits for a start trigger. It then stores packets until a stop trigger arrives, and after that it holds. A debugger reads back a status word and any stored entry through a one-cycle read port.

The write pointer has a sticky wrap flag that sits above the 6-bit index, which lets the debugger tell which entries hold valid data. While the flag is clear, entries 0 up to index-1 are valid. Once it is set, every entry is valid, and the oldest entry is the one at the index. The index, the flag and the stored entries survive disable, the stop trigger and a system reset, so a capture can be read out after any of these. Three events start a fresh capture: a write of the self-clearing reset bit, turning the buffer on, or a debugger GO command in obtrusive mode. Each of them clears the index, the wrap flag and any half-built entry.

Top module: `trace_rec_ctrl`

## Requirements
- R1: The state field encodes 00 off, 01 armed, 10 recording, 11 done. A start trigger moves armed to recording, a stop trigger moves recording to done, and done holds until a trace reset or disable.
- R2: A start trigger in any state other than armed, and a stop trigger in any state other than recording, have no effect.
- R3: Packets are taken only in state 10. Each group of PACK packets (PKT_W bits each, first packet in the low bits) forms one entry, which is written at the index; the index then advances by one.
- R4: When the index steps from 63 to 0, the wrap flag (status bit 14) sets, and it stays set until a trace reset.
- R5: A trace reset clears the index and the wrap flag and sets the state to 01 if enabled or 00 if not. It is caused by a control write with bit 1 set, by a control write with bit 0 set while disabled, or by go_cmd while obtrusive_mode is 1. go_cmd without obtrusive_mode, and a write that keeps an enabled buffer enabled, cause no trace reset.
- R6: Status bit 1, the position of the reset control bit, always reads 0.
- R7: The status word is: bit 0 enable, bits 3:2 state, bits 13:8 index, bit 14 wrap flag, all other bits 0. Control write bit 0 sets the enable; control bits 7:2 are ignored.
- R8: Disable, the stop trigger and system reset leave the index, the wrap flag and the stored entries unchanged. System reset clears the enable and sets the state to 00.
- R9: rd_data returns the entry at rd_idx one cycle after rd_idx is presented, in every state. A write to the same entry in the same cycle returns the old contents.
- R10: A trace reset in the same cycle as a packet wins: the packet is not taken and nothing is written.
- R11: A trace reset discards packets already collected for an unfinished entry, so the next entry holds only packets taken after the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| pkt_valid | input | 1 | Packet strobe |
| pkt_data | input | PKT_W | Packet value |
| trig_start | input | 1 | Start trigger pulse |
| trig_stop | input | 1 | Stop trigger pulse |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | CTL_W | Control write data: bit 0 enable, bit 1 trace reset |
| go_cmd | input | 1 | Debugger GO command pulse |
| obtrusive_mode | input | 1 | Obtrusive trace mode flag |
| status_rdata | output | 9+IDX_W | Status word |
| rd_idx | input | IDX_W | Read index |
| rd_data | output | PKT_W*PACK | Stored entry at the previous cycle's rd_idx |

## Verification
The state, index and wrap flag all appear directly in the status word. A wrong transition or a wrong pointer step is therefore visible at the port on the next clock edge, and the reference model compares the status word every cycle. A wrong packer count or a stale partial entry does not change the status. It appears only as wrong contents when that entry is read back, one cycle after the read index is presented. For this reason the bench reads back entries written just after trace resets and after a wrap.

// File: rtl/trace_rec_pkg.sv
package trace_rec_pkg;

    typedef enum logic [1:0] {
        TR_OFF   = 2'b00,
        TR_ARMED = 2'b01,
        TR_REC   = 2'b10,
        TR_DONE  = 2'b11
    } trace_state_e;

    typedef struct packed {
        logic trace_rst;
        logic en_next;
    } ctl_evt_t;

    localparam int CTL_EN_BIT  = 0;
    localparam int CTL_RST_BIT = 1;

    localparam int ST_EN    = 0;
    localparam int ST_RSTB  = 1;
    localparam int ST_STATE = 2;
    localparam int ST_IDX   = 8;

    function automatic trace_state_e fsm_next(
        input trace_state_e cur,
        input ctl_evt_t     ev,
        input logic         start,
        input logic         stop
    );
        trace_state_e nxt;
        nxt = cur;
        if (ev.trace_rst) begin
            nxt = ev.en_next ? TR_ARMED : TR_OFF;
        end else if (!ev.en_next) begin
            nxt = TR_OFF;
        end else begin
            case (cur)
                TR_ARMED: if (start) nxt = TR_REC;
                TR_REC:   if (stop)  nxt = TR_DONE;
                default:  nxt = cur;
            endcase
        end
        return nxt;
    endfunction

endpackage

// File: rtl/trace_ctl_regs.sv
module trace_ctl_regs
    import trace_rec_pkg::*;
#(
    parameter int CTL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_we,
    input  logic [CTL_W-1:0] ctrl_wdata,
    input  logic             go_cmd,
    input  logic             obtrusive,
    output logic             en_q,
    output ctl_evt_t         evt
);

    logic wr_en_bit;
    logic wr_rst_bit;
    logic ctl_unused;

    assign wr_en_bit  = ctrl_wdata[CTL_EN_BIT];
    assign wr_rst_bit = ctrl_wdata[CTL_RST_BIT];
    assign ctl_unused = ^ctrl_wdata;

    always_comb begin
        evt.en_next   = 1'b0;
        evt.trace_rst = 1'b0;
        if (!rst) begin
            evt.en_next   = ctrl_we ? wr_en_bit : en_q;
            evt.trace_rst = (ctrl_we && wr_rst_bit)
                          || (ctrl_we && wr_en_bit && !en_q)
                          || (go_cmd && obtrusive);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= evt.en_next;
    end

    // R5
    go_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_we && !(go_cmd && obtrusive)) |-> !evt.trace_rst);

endmodule

// File: rtl/trace_rec_fsm.sv
module trace_rec_fsm
    import trace_rec_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  ctl_evt_t     evt,
    input  logic         trig_start,
    input  logic         trig_stop,
    output trace_state_e state_q
);

    always_ff @(posedge clk) begin
        if (rst) state_q <= TR_OFF;
        else     state_q <= fsm_next(state_q, evt, trig_start, trig_stop);
    end

    // R1
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == TR_DONE && !evt.trace_rst && evt.en_next) |=> state_q == TR_DONE);

    // R2
    armed_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == TR_ARMED && !trig_start && !evt.trace_rst && evt.en_next)
        |=> state_q == TR_ARMED);

    // R1
    off_when_disabled_chk: assert property (@(posedge clk) disable iff (rst)
        (!evt.en_next) |=> state_q == TR_OFF);

endmodule

// File: rtl/trace_packer.sv
module trace_packer #(
    parameter int PKT_W = 4,
    parameter int PACK  = 2,
    parameter int ENT_W = PKT_W * PACK
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             take,
    input  logic [PKT_W-1:0] pkt,
    output logic             ent_valid,
    output logic [ENT_W-1:0] entry
);

    generate
        if (PACK == 1) begin : g_direct
            assign entry     = pkt;
            assign ent_valid = take;
        end else begin : g_pack
            localparam int CNT_W = $clog2(PACK);
            localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(PACK - 1);

            logic [CNT_W-1:0]            cnt_q;
            logic [PACK-2:0][PKT_W-1:0]  hold_q;

            always_ff @(posedge clk) begin
                if (rst || flush) begin
                    cnt_q <= '0;
                end else if (take) begin
                    if (cnt_q == LAST_SLOT) cnt_q <= '0;
                    else                    cnt_q <= cnt_q + 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (take && cnt_q != LAST_SLOT) hold_q[cnt_q] <= pkt;
            end

            assign entry     = {pkt, hold_q};
            assign ent_valid = take && (cnt_q == LAST_SLOT);

            // R11
            flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
                flush |=> cnt_q == '0);
        end
    endgenerate

endmodule

// File: rtl/trace_wr_ptr.sv
module trace_wr_ptr #(
    parameter int DEPTH = 64,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             adv,
    output logic [IDX_W-1:0] idx_q,
    output logic             wrap_q
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (clr) begin
            idx_q  <= '0;
            wrap_q <= 1'b0;
        end else if (adv) begin
            if (idx_q == LAST_IDX) begin
                idx_q  <= '0;
                wrap_q <= 1'b1;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/trace_store.sv
module trace_store #(
    parameter int DEPTH = 64,
    parameter int ENT_W = 8,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [ENT_W-1:0] wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [ENT_W-1:0] rdata
);

    logic [ENT_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/trace_rec_ctrl.sv
module trace_rec_ctrl
    import trace_rec_pkg::*;
#(
    parameter int PKT_W = 4,
    parameter int PACK  = 2,
    parameter int DEPTH = 64,
    parameter int CTL_W = 8,
    parameter int IDX_W = $clog2(DEPTH),
    parameter int ENT_W = PKT_W * PACK,
    parameter int STAT_W = ST_IDX + IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pkt_valid,
    input  logic [PKT_W-1:0]  pkt_data,
    input  logic              trig_start,
    input  logic              trig_stop,
    input  logic              ctrl_we,
    input  logic [CTL_W-1:0]  ctrl_wdata,
    input  logic              go_cmd,
    input  logic              obtrusive_mode,
    output logic [STAT_W-1:0] status_rdata,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ENT_W-1:0]  rd_data
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    logic             en_q;
    ctl_evt_t         evt;
    trace_state_e     state_q;
    logic             take;
    logic             ent_valid;
    logic [ENT_W-1:0] entry;
    logic [IDX_W-1:0] idx_q;
    logic             wrap_q;

    trace_ctl_regs #(.CTL_W(CTL_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .go_cmd     (go_cmd),
        .obtrusive  (obtrusive_mode),
        .en_q       (en_q),
        .evt        (evt)
    );

    trace_rec_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .trig_start (trig_start),
        .trig_stop  (trig_stop),
        .state_q    (state_q)
    );

    assign take = pkt_valid && !rst && (state_q == TR_REC)
               && !evt.trace_rst && evt.en_next;

    trace_packer #(.PKT_W(PKT_W), .PACK(PACK), .ENT_W(ENT_W)) u_pack (
        .clk       (clk),
        .rst       (rst),
        .flush     (evt.trace_rst),
        .take      (take),
        .pkt       (pkt_data),
        .ent_valid (ent_valid),
        .entry     (entry)
    );

    trace_wr_ptr #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ptr (
        .clk    (clk),
        .clr    (evt.trace_rst),
        .adv    (ent_valid),
        .idx_q  (idx_q),
        .wrap_q (wrap_q)
    );

    trace_store #(.DEPTH(DEPTH), .ENT_W(ENT_W), .IDX_W(IDX_W)) u_store (
        .clk   (clk),
        .we    (ent_valid),
        .waddr (idx_q),
        .wdata (entry),
        .raddr (rd_idx),
        .rdata (rd_data)
    );

    always_comb begin
        status_rdata                    = '0;
        status_rdata[ST_EN]             = en_q;
        status_rdata[ST_RSTB]           = 1'b0;
        status_rdata[ST_STATE +: 2]     = state_q;
        status_rdata[ST_IDX +: IDX_W]   = idx_q;
        status_rdata[ST_IDX + IDX_W]    = wrap_q;
    end

    // R3
    idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ent_valid && idx_q != LAST_IDX) |=> idx_q == $past(idx_q) + 1'b1);

    // R4
    wrap_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (wrap_q && !evt.trace_rst) |=> wrap_q);

    // R5
    ptr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        evt.trace_rst |=> (idx_q == '0 && !wrap_q));

    // R8
    ptr_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!ent_valid && !evt.trace_rst) |=> ($stable(idx_q) && $stable(wrap_q)));

    // R10
    reset_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.trace_rst && pkt_valid) |-> !ent_valid);

endmodule

// File: tb/trace_rec_ctrl_tb.sv
`timescale 1ns/1ps
module trace_rec_ctrl_tb_top;

    localparam int PKT_W  = 4;
    localparam int PACK   = 2;
    localparam int DEPTH  = 64;
    localparam int IDX_W  = 6;
    localparam int ENT_W  = 8;
    localparam int STAT_W = 15;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              pkt_valid = 1'b0;
    logic [PKT_W-1:0]  pkt_data = '0;
    logic              trig_start = 1'b0;
    logic              trig_stop = 1'b0;
    logic              ctrl_we = 1'b0;
    logic [7:0]        ctrl_wdata = '0;
    logic              go_cmd = 1'b0;
    logic              obtrusive_mode = 1'b0;
    logic [STAT_W-1:0] status_rdata;
    logic [IDX_W-1:0]  rd_idx = '0;
    logic [ENT_W-1:0]  rd_data;

    always #4 clk = ~clk;

    trace_rec_ctrl dut_i (
        .clk            (clk),
        .rst            (rst),
        .pkt_valid      (pkt_valid),
        .pkt_data       (pkt_data),
        .trig_start     (trig_start),
        .trig_stop      (trig_stop),
        .ctrl_we        (ctrl_we),
        .ctrl_wdata     (ctrl_wdata),
        .go_cmd         (go_cmd),
        .obtrusive_mode (obtrusive_mode),
        .status_rdata   (status_rdata),
        .rd_idx         (rd_idx),
        .rd_data        (rd_data)
    );

    int checks = 0;
    int errors = 0;

    // behavioural reference
    int m_en = 0, m_state = 0, m_idx = 0, m_wrap = 0;
    bit m_known = 0;
    int m_mem [DEPTH];
    bit m_valid [DEPTH];
    int m_part [$];
    int m_rd = 0;
    bit m_rdv = 0;

    always @(posedge clk) begin
        int nen;
        bit trst;
        int word;
        m_rdv = m_valid[int'(rd_idx)];
        m_rd  = m_mem[int'(rd_idx)];
        if (rst) begin
            m_en = 0; m_state = 0; m_part.delete();
        end else begin
            nen  = ctrl_we ? int'(ctrl_wdata[0]) : m_en;
            trst = (ctrl_we && ctrl_wdata[1]) || (ctrl_we && ctrl_wdata[0] && m_en == 0)
                   || (go_cmd && obtrusive_mode);
            if (trst) begin
                m_idx = 0; m_wrap = 0; m_known = 1; m_part.delete();
                m_state = (nen != 0) ? 1 : 0;
            end else if (nen == 0) begin
                m_state = 0;
            end else begin
                if (m_state == 2 && pkt_valid) begin
                    m_part.push_back(int'(pkt_data));
                    if (m_part.size() == PACK) begin
                        word = 0;
                        for (int i = 0; i < PACK; i++) word |= m_part[i] << (i * PKT_W);
                        m_mem[m_idx] = word;
                        m_valid[m_idx] = 1;
                        m_part.delete();
                        if (m_idx == DEPTH - 1) begin m_idx = 0; m_wrap = 1; end
                        else m_idx++;
                    end
                end
                if (m_state == 1 && trig_start) m_state = 2;
                else if (m_state == 2 && trig_stop) m_state = 3;
            end
            m_en = nen;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        chk(int'(status_rdata[3:2]) == m_state, "R1 state field", int'(status_rdata[3:2]), m_state);
        chk(int'(status_rdata[0]) == m_en, "R7 enable bit", int'(status_rdata[0]), m_en);
        chk(status_rdata[1] == 1'b0, "R6 reset bit reads 0", int'(status_rdata[1]), 0);
        chk(status_rdata[7:4] == 4'h0, "R7 reserved bits", int'(status_rdata[7:4]), 0);
        if (m_known) begin
            chk(int'(status_rdata[13:8]) == m_idx, "R3 index", int'(status_rdata[13:8]), m_idx);
            chk(int'(status_rdata[14]) == m_wrap, "R4 wrap flag", int'(status_rdata[14]), m_wrap);
        end
        if (m_rdv)
            chk(int'(rd_data) == m_rd, "R9 read port", int'(rd_data), m_rd);
        ctrl_we = 1'b0; ctrl_wdata = '0; trig_start = 1'b0; trig_stop = 1'b0;
        go_cmd = 1'b0; obtrusive_mode = 1'b0; pkt_valid = 1'b0;
    endtask

    task automatic wr_ctl(input logic [7:0] d);
        ctrl_we = 1'b1; ctrl_wdata = d; tick();
    endtask

    task automatic send(input logic [3:0] d);
        pkt_valid = 1'b1; pkt_data = d; tick();
    endtask

    task automatic read_at(input int i);
        rd_idx = IDX_W'(i); tick();
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        @(negedge clk); tick(); tick();
        rst = 1'b0;
        tick();
        chk(status_rdata[3:0] == 4'h0, "R8 system reset state off", int'(status_rdata[3:0]), 0);

        wr_ctl(8'hFD);                                  // enable, reserved bits set
        chk(status_rdata == 15'h0005, "R7 R5 enable clears pointer", int'(status_rdata), 'h5);

        trig_stop = 1'b1; pkt_valid = 1'b1; pkt_data = 4'h9; tick();
        chk(status_rdata == 15'h0005, "R2 stop ignored while armed", int'(status_rdata), 'h5);

        trig_start = 1'b1; tick();
        chk(status_rdata == 15'h0009, "R1 armed to recording", int'(status_rdata), 'h9);

        send(4'h1); send(4'h2); send(4'h3); send(4'h4); send(4'h5);
        chk(status_rdata == 15'h0209, "R3 two entries stored", int'(status_rdata), 'h209);
        read_at(1);
        chk(rd_data == 8'h43, "R3 packing order", int'(rd_data), 'h43);

        trig_start = 1'b1; tick();
        chk(status_rdata == 15'h0209, "R2 start ignored while recording", int'(status_rdata), 'h209);

        ctrl_we = 1'b1; ctrl_wdata = 8'h03; pkt_valid = 1'b1; pkt_data = 4'h6; tick();
        chk(status_rdata == 15'h0005, "R10 reset beats packet", int'(status_rdata), 'h5);
        chk(status_rdata[1] == 1'b0, "R6 reset bit clears itself", int'(status_rdata[1]), 0);

        trig_start = 1'b1; tick();
        send(4'h7); send(4'h8);
        read_at(0);
        chk(rd_data == 8'h87, "R11 partial discarded by reset bit", int'(rd_data), 'h87);

        for (int i = 0; i < 128; i++) send(4'(i));
        chk(status_rdata == 15'h4109, "R4 wrap after 64 entries", int'(status_rdata), 'h4109);
        read_at(0);
        chk(rd_data == 8'hFE, "R4 entry 63 to 0 written", int'(rd_data), 'hFE);

        send(4'h9); send(4'hA);
        chk(status_rdata == 15'h4209, "R4 wrap stays set", int'(status_rdata), 'h4209);

        trig_stop = 1'b1; tick();
        chk(status_rdata == 15'h420D, "R1 recording to done", int'(status_rdata), 'h420D);
        send(4'h1); send(4'h2); trig_start = 1'b1; tick();
        chk(status_rdata == 15'h420D, "R2 R3 done holds and ignores packets", int'(status_rdata), 'h420D);

        wr_ctl(8'h01);
        chk(status_rdata == 15'h420D, "R5 enable rewrite no reset", int'(status_rdata), 'h420D);

        wr_ctl(8'h00);
        chk(status_rdata == 15'h4200, "R8 disable keeps pointer", int'(status_rdata), 'h4200);
        read_at(1);
        chk(rd_data == 8'hA9, "R9 read while disabled", int'(rd_data), 'hA9);

        rst = 1'b1; tick(); tick(); rst = 1'b0; tick();
        chk(status_rdata == 15'h4200, "R8 system reset keeps pointer", int'(status_rdata), 'h4200);
        read_at(1);
        chk(rd_data == 8'hA9, "R8 contents kept over reset", int'(rd_data), 'hA9);

        go_cmd = 1'b1; tick();
        chk(status_rdata == 15'h4200, "R5 go without obtrusive ignored", int'(status_rdata), 'h4200);
        go_cmd = 1'b1; obtrusive_mode = 1'b1; tick();
        chk(status_rdata == 15'h0000, "R5 obtrusive go clears", int'(status_rdata), 0);

        wr_ctl(8'h01);
        trig_start = 1'b1; tick();
        send(4'hC);
        go_cmd = 1'b1; obtrusive_mode = 1'b1; tick();
        chk(status_rdata == 15'h0005, "R5 go rearms enabled buffer", int'(status_rdata), 'h5);
        trig_start = 1'b1; tick();
        send(4'h3); send(4'hD);
        read_at(0);
        chk(rd_data == 8'hD3, "R11 partial discarded by go", int'(rd_data), 'hD3);

        tick();
        finish_run();
    end

endmodule